// File: doc/BRIEF.md
# Translator Control and Fault Register Block

This block is the software-visible register file that sits beside an I/O address translator. It holds the translator's enable bit, the size of the translated window and the base of the page table, and drives them out as plain control pins. It also holds two flush registers, an arbiter enable word, an arbitration enable word, four per-slot bus configuration words and a mask identifier. Every bus write passes through a per-register keep mask, and some registers have bits that are always set.

When the translator reports a failed translation on its fault pins, the block captures a fault status word and the faulting address and raises an interrupt. Software clears the interrupt by reading or writing either of those two registers. Offsets that name no register act as small general-purpose storage. Bus accesses are word-addressed. A write takes effect on the clock edge that samples the strobe, and read data comes back registered one cycle after the read strobe. The register port always accepts, so it has no back-pressure.

Top module: `iommu_ctl_regs`

## Requirements
- R1: After reset these registers read as follows: control = VERSION<<24, fault status 0x00800000, arbiter enable 0x00000003, arbitration enable 0x00000008, mask ID 0x23000000. All others read zero and irq is low.
- R2: A write to control (byte offset 0x0000) stores (data & 0x0000001D) with VERSION in bits [31:24]. xl_enable follows bit 0 and xl_range follows bits [4:2].
- R3: A write to table base (0x0004) stores (data & 0x07FFFC00), and xl_base shows the stored value.
- R4: The whole-table flush word (0x0014) and the single-page flush word (0x0018) store all 32 bits written.
- R5: A write to arbiter enable (0x1008) stores (data & 0x801F000F) with bit 0 set.
- R6: A write to arbitration enable (0x2000) stores (data & 0x001F0000) with bit 3 set.
- R7: The four slot configuration words (0x1010, 0x1014, 0x1018, 0x101C) are independent, and each stores (data & 0x00010003).
- R8: A write to fault status (0x1000) stores (data & 0xFF0FFFFF) with bit 23 set. A write to fault address (0x1004) stores all 32 bits.
- R9: A write to mask ID (0x3018) ORs (data & 0x00FFFFFF) into the current contents, so its bits are never cleared by a write.
- R10: A cycle with flt_valid high loads fault status with bits 31, 30, 23 and 17 set, plus bit 18 when flt_read is high, loads fault address with flt_addr, and drives irq high on the next cycle.
- R11: Any read or write of fault status or fault address in a cycle without flt_valid drives irq low on the next cycle.
- R12: When flt_valid and a bus write to fault status or fault address fall in the same cycle, the fault values are stored and irq stays high.
- R13: A read strobe in cycle N gives bus_rvalid high and bus_rdata equal to the register contents at cycle N in cycle N+1. In any cycle without a read strobe, bus_rvalid is low.
- R14: Offsets that name no register are 32-bit read/write storage of SCRATCH_WORDS words (default 8), selected by word index modulo SCRATCH_WORDS. For example, 0x0020 and 0x3000 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Single-cycle write strobe |
| bus_rd_en | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | bus_rdata is valid this cycle |
| flt_valid | input | 1 | Translator reports a fault this cycle |
| flt_read | input | 1 | The faulting access was a read |
| flt_addr | input | 32 | Faulting address |
| irq | output | 1 | Fault interrupt, level |
| xl_enable | output | 1 | Translation enable |
| xl_range | output | 3 | Window size code |
| xl_base | output | 32 | Page table base |

## Verification
The assertions assume that read and write strobes never fall in the same cycle and that every address is word aligned. The assertions on fault status assume that flt_read is meaningful only while flt_valid is high. The stimulus makes at most one bus access per clock and always uses aligned offsets. It pulses the fault pins for single cycles, both alone and together with a write to a fault register, so that the clearing path and the priority path each get exercised.

// File: rtl/iommu_ctl_pkg.sv
package iommu_ctl_pkg;

  localparam logic [15:0] OFS_CTRL  = 16'h0000;
  localparam logic [15:0] OFS_BASE  = 16'h0004;
  localparam logic [15:0] OFS_TLBF  = 16'h0014;
  localparam logic [15:0] OFS_PGF   = 16'h0018;
  localparam logic [15:0] OFS_FSR   = 16'h1000;
  localparam logic [15:0] OFS_FAR   = 16'h1004;
  localparam logic [15:0] OFS_AEN   = 16'h1008;
  localparam logic [15:0] OFS_SLOT0 = 16'h1010;
  localparam logic [15:0] OFS_ARB   = 16'h2000;
  localparam logic [15:0] OFS_MID   = 16'h3018;
  localparam int unsigned NUM_SLOTS = 4;

  localparam logic [31:0] CTRL_KEEP = 32'h0000_001D;
  localparam logic [31:0] BASE_KEEP = 32'h07FF_FC00;
  localparam logic [31:0] AEN_KEEP  = 32'h801F_000F;
  localparam logic [31:0] AEN_SET   = 32'h0000_0001;
  localparam logic [31:0] ARB_KEEP  = 32'h001F_0000;
  localparam logic [31:0] ARB_SET   = 32'h0000_0008;
  localparam logic [31:0] FSR_KEEP  = 32'hFF0F_FFFF;
  localparam logic [31:0] FSR_SET   = 32'h0080_0000;
  localparam logic [31:0] SLOT_KEEP = 32'h0001_0003;
  localparam logic [31:0] MID_KEEP  = 32'h00FF_FFFF;

  localparam logic [31:0] FSR_FAULT = 32'hC082_0000;
  localparam logic [31:0] FSR_RDBIT = 32'h0004_0000;

  localparam logic [31:0] AEN_RST = 32'h0000_0003;
  localparam logic [31:0] ARB_RST = 32'h0000_0008;
  localparam logic [31:0] MID_RST = 32'h2300_0000;

  typedef struct packed {
    logic                 ctrl;
    logic                 base;
    logic                 tlbf;
    logic                 pgf;
    logic                 fsr;
    logic                 far;
    logic                 aen;
    logic                 arb;
    logic                 mid;
    logic [NUM_SLOTS-1:0] slot;
    logic                 scr;
  } reg_sel_t;

endpackage

// File: rtl/iommu_ctl_decode.sv
module iommu_ctl_decode
  import iommu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  logic [15:0] word_a;

  always_comb begin
    word_a = 16'(addr) & 16'hFFFC;
    sel = '0;
    sel.ctrl = (word_a == OFS_CTRL);
    sel.base = (word_a == OFS_BASE);
    sel.tlbf = (word_a == OFS_TLBF);
    sel.pgf  = (word_a == OFS_PGF);
    sel.fsr  = (word_a == OFS_FSR);
    sel.far  = (word_a == OFS_FAR);
    sel.aen  = (word_a == OFS_AEN);
    sel.arb  = (word_a == OFS_ARB);
    sel.mid  = (word_a == OFS_MID);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      sel.slot[i] = (word_a == (OFS_SLOT0 + 16'(4 * i)));
    end
    sel.scr = ~(sel.ctrl | sel.base | sel.tlbf | sel.pgf | sel.fsr | sel.far |
                sel.aen | sel.arb | sel.mid | (|sel.slot));
  end

  always_comb begin
    assert ($onehot0({sel.ctrl, sel.base, sel.tlbf, sel.pgf, sel.fsr, sel.far,
                      sel.aen, sel.arb, sel.mid, sel.slot}))
      else $error("a_r14_decode_onehot: several registers hit");
  end

endmodule

// File: rtl/iommu_ctl_fault.sv
module iommu_ctl_fault
  import iommu_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flt_valid,
  input  logic        flt_read,
  input  logic [31:0] flt_addr,
  input  logic        wr_fsr,
  input  logic        wr_far,
  input  logic        sw_touch,
  input  logic [31:0] wdata,
  output logic [31:0] fsr_q,
  output logic [31:0] far_q,
  output logic        irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= FSR_SET;
      far_q <= '0;
      irq   <= 1'b0;
    end else if (flt_valid) begin
      fsr_q <= FSR_FAULT | (flt_read ? FSR_RDBIT : 32'h0);
      far_q <= flt_addr;
      irq   <= 1'b1;
    end else begin
      if (wr_fsr) fsr_q <= (wdata & FSR_KEEP) | FSR_SET;
      if (wr_far) far_q <= wdata;
      if (sw_touch) irq <= 1'b0;
    end
  end

  a_r10_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (irq && fsr_q[31] && fsr_q[17] && far_q == $past(flt_addr)))
    else $error("a_r10_fault_capture");

  a_r10_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (fsr_q[18] == $past(flt_read)))
    else $error("a_r10_read_flag");

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_touch && !flt_valid) |=> !irq)
    else $error("a_r11_clear");

  a_r12_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && wr_fsr) |=> (fsr_q[31:30] == 2'b11 && irq))
    else $error("a_r12_fault_wins");

  a_r8_resv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fsr |=> fsr_q[23])
    else $error("a_r8_resv_bit");

endmodule

// File: rtl/iommu_ctl_scratch.sv
module iommu_ctl_scratch #(
  parameter int unsigned WORDS = 8,
  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  logic [31:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (we && idx == IW'(g)) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

endmodule

// File: rtl/iommu_ctl_regs.sv
module iommu_ctl_regs
  import iommu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 14,
  parameter logic [7:0]  VERSION       = 8'h41,
  parameter int unsigned SCRATCH_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              flt_valid,
  input  logic              flt_read,
  input  logic [31:0]       flt_addr,
  output logic              irq,
  output logic              xl_enable,
  output logic [2:0]        xl_range,
  output logic [31:0]       xl_base
);

  localparam int unsigned SIW = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [31:0] CTRL_RST = {VERSION, 24'h0};

  reg_sel_t    sel;
  logic [31:0] ctrl_q, base_q, tlbf_q, pgf_q, aen_q, arb_q, mid_q;
  logic [31:0] slot_q [NUM_SLOTS];
  logic [31:0] fsr_q, far_q, scr_rd, rd_mux;
  logic        sw_touch;

  iommu_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign sw_touch = (bus_wr_en | bus_rd_en) & (sel.fsr | sel.far);

  iommu_ctl_fault u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_valid (flt_valid),
    .flt_read  (flt_read),
    .flt_addr  (flt_addr),
    .wr_fsr    (bus_wr_en & sel.fsr),
    .wr_far    (bus_wr_en & sel.far),
    .sw_touch  (sw_touch),
    .wdata     (bus_wdata),
    .fsr_q     (fsr_q),
    .far_q     (far_q),
    .irq       (irq)
  );

  iommu_ctl_scratch #(.WORDS(SCRATCH_WORDS)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_wr_en & sel.scr),
    .idx   (bus_addr[2 +: SIW]),
    .wdata (bus_wdata),
    .rdata (scr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      base_q <= '0;
      tlbf_q <= '0;
      pgf_q  <= '0;
      aen_q  <= AEN_RST;
      arb_q  <= ARB_RST;
      mid_q  <= MID_RST;
    end else if (bus_wr_en) begin
      if (sel.ctrl) ctrl_q <= (bus_wdata & CTRL_KEEP) | CTRL_RST;
      if (sel.base) base_q <= bus_wdata & BASE_KEEP;
      if (sel.tlbf) tlbf_q <= bus_wdata;
      if (sel.pgf)  pgf_q  <= bus_wdata;
      if (sel.aen)  aen_q  <= (bus_wdata & AEN_KEEP) | AEN_SET;
      if (sel.arb)  arb_q  <= (bus_wdata & ARB_KEEP) | ARB_SET;
      if (sel.mid)  mid_q  <= mid_q | (bus_wdata & MID_KEEP);
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (bus_wr_en && sel.slot[s]) slot_q[s] <= bus_wdata & SLOT_KEEP;
    end
  end

  always_comb begin
    rd_mux = scr_rd;
    if (sel.ctrl) rd_mux = ctrl_q;
    if (sel.base) rd_mux = base_q;
    if (sel.tlbf) rd_mux = tlbf_q;
    if (sel.pgf)  rd_mux = pgf_q;
    if (sel.fsr)  rd_mux = fsr_q;
    if (sel.far)  rd_mux = far_q;
    if (sel.aen)  rd_mux = aen_q;
    if (sel.arb)  rd_mux = arb_q;
    if (sel.mid)  rd_mux = mid_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel.slot[i]) rd_mux = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end

  assign xl_enable = ctrl_q[0];
  assign xl_range  = ctrl_q[4:2];
  assign xl_base   = base_q;

  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rvalid)
    else $error("a_r13_read_valid");

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rvalid)
    else $error("a_r13_idle_quiet");

  a_r9_mid_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mid_q & $past(mid_q)) == 32'h0))
    else $error("a_r9_mid_monotone");

  a_r2_range_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel.ctrl) |=> (xl_range == $past(bus_wdata[4:2])))
    else $error("a_r2_range_follows");

  a_r3_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && sel.base) |=> $stable(xl_base))
    else $error("a_r3_base_held");

endmodule

// File: tb/iommu_ctl_regs_tb.sv
module iommu_ctl_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VER = 8'h41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        flt_valid = 1'b0, flt_read = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        irq, xl_enable;
  logic [2:0]  xl_range;
  logic [31:0] xl_base;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_ctl_regs #(.ADDR_W(14), .VERSION(VER), .SCRATCH_WORDS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .flt_valid(flt_valid), .flt_read(flt_read),
    .flt_addr(flt_addr), .irq(irq), .xl_enable(xl_enable),
    .xl_range(xl_range), .xl_base(xl_base)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Monitor: pops an expected item for each returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (q_exp.size() == 0) begin
        chk(bus_rdata, 32'hxxxxxxxx, "R13 unexpected rvalid");
      end else begin
        chk(bus_rdata, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
    bus_rd_en = 1'b1; bus_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic fault(input logic [31:0] a, input logic r);
    flt_valid = 1'b1; flt_addr = a; flt_read = r;
    @(negedge clk);
    flt_valid = 1'b0; flt_read = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({31'h0, irq}, 32'h0, "R1 irq after reset");
    rd(14'h0000, {VER, 24'h0}, "R1 control reset");
    rd(14'h0004, 32'h0, "R1 base reset");
    rd(14'h1000, 32'h0080_0000, "R1 fault status reset");
    rd(14'h1004, 32'h0, "R1 fault address reset");
    rd(14'h1008, 32'h0000_0003, "R1 arbiter enable reset");
    rd(14'h2000, 32'h0000_0008, "R1 arbitration enable reset");
    rd(14'h3018, 32'h2300_0000, "R1 mask id reset");
    rd(14'h1014, 32'h0, "R1 slot reset");

    // R2 control
    wr(14'h0000, 32'hFFFF_FFFF);
    chk({31'h0, xl_enable}, 32'h1, "R2 enable pin");
    chk({29'h0, xl_range}, 32'h7, "R2 range pin");
    rd(14'h0000, {VER, 24'h1D}, "R2 control all ones");
    wr(14'h0000, 32'h0000_0008);
    chk({29'h0, xl_range}, 32'h2, "R2 range pin code 2");
    rd(14'h0000, {VER, 24'h08}, "R2 control range only");

    // R3 base
    wr(14'h0004, 32'hFFFF_FFFF);
    chk(xl_base, 32'h07FF_FC00, "R3 base pin");
    rd(14'h0004, 32'h07FF_FC00, "R3 base read");

    // R4 flush words
    wr(14'h0014, 32'hDEAD_BEEF);
    wr(14'h0018, 32'h1234_5678);
    rd(14'h0014, 32'hDEAD_BEEF, "R4 tlb flush word");
    rd(14'h0018, 32'h1234_5678, "R4 page flush word");

    // R5 / R6
    wr(14'h1008, 32'h0);
    rd(14'h1008, 32'h0000_0001, "R5 arbiter zero write");
    wr(14'h1008, 32'hFFFF_FFFF);
    rd(14'h1008, 32'h801F_000F, "R5 arbiter ones write");
    wr(14'h2000, 32'hFFFF_FFFF);
    rd(14'h2000, 32'h001F_0008, "R6 arbitration ones");
    wr(14'h2000, 32'h0);
    rd(14'h2000, 32'h0000_0008, "R6 arbitration zero");

    // R7 slots
    wr(14'h1010, 32'hFFFF_FFFF);
    wr(14'h1014, 32'h0000_0002);
    wr(14'h1018, 32'h0001_0000);
    wr(14'h101C, 32'hF000_0001);
    rd(14'h1010, 32'h0001_0003, "R7 slot0");
    rd(14'h1014, 32'h0000_0002, "R7 slot1");
    rd(14'h1018, 32'h0001_0000, "R7 slot2");
    rd(14'h101C, 32'h0000_0001, "R7 slot3");

    // R8 fault register writes
    wr(14'h1000, 32'hFFFF_FFFF);
    rd(14'h1000, 32'hFF8F_FFFF, "R8 status ones");
    wr(14'h1000, 32'h0);
    rd(14'h1000, 32'h0080_0000, "R8 status zero");
    wr(14'h1004, 32'hCAFE_F00D);
    rd(14'h1004, 32'hCAFE_F00D, "R8 address word");

    // R9 mask id
    wr(14'h3018, 32'hFF00_0F0F);
    rd(14'h3018, 32'h2300_0F0F, "R9 mask id first or");
    wr(14'h3018, 32'h0000_00F0);
    rd(14'h3018, 32'h2300_0FFF, "R9 mask id accumulate");
    wr(14'h3018, 32'h0);
    rd(14'h3018, 32'h2300_0FFF, "R9 mask id zero write");

    // R10 / R11 read fault, cleared by status read
    fault(32'hFF00_1000, 1'b1);
    chk({31'h0, irq}, 32'h1, "R10 irq raised");
    rd(14'h1000, 32'hC086_0000, "R10 status read fault");
    chk({31'h0, irq}, 32'h0, "R11 cleared by status read");
    rd(14'h1004, 32'hFF00_1000, "R10 fault address");

    // write fault, cleared by address write
    fault(32'hFE00_2000, 1'b0);
    chk({31'h0, irq}, 32'h1, "R10 irq raised write fault");
    rd(14'h1000, 32'hC082_0000, "R10 status write fault");
    chk({31'h0, irq}, 32'h0, "R11 cleared by status read 2");
    fault(32'hFE00_3000, 1'b0);
    wr(14'h1004, 32'h0);
    chk({31'h0, irq}, 32'h0, "R11 cleared by address write");
    fault(32'hFE00_4000, 1'b1);
    rd(14'h1004, 32'hFE00_4000, "R11 address read");
    chk({31'h0, irq}, 32'h0, "R11 cleared by address read");
    fault(32'hFE00_5000, 1'b1);
    wr(14'h1000, 32'h0);
    chk({31'h0, irq}, 32'h0, "R11 cleared by status write");

    // R12 priority
    flt_valid = 1'b1; flt_addr = 32'hF800_6000; flt_read = 1'b0;
    bus_wr_en = 1'b1; bus_addr = 14'h1000; bus_wdata = 32'h0;
    @(negedge clk);
    flt_valid = 1'b0; bus_wr_en = 1'b0;
    chk({31'h0, irq}, 32'h1, "R12 irq kept");
    chk({31'h0, irq}, 32'h1, "R12 irq still high before access");
    rd(14'h1000, 32'hC082_0000, "R12 fault status kept");
    rd(14'h1004, 32'hF800_6000, "R12 fault address kept");

    // R14 scratch aliasing
    wr(14'h0020, 32'hA5A5_0001);
    wr(14'h000C, 32'h5A5A_0002);
    rd(14'h3000, 32'hA5A5_0001, "R14 alias word 0");
    rd(14'h000C, 32'h5A5A_0002, "R14 word 3");
    rd(14'h0020, 32'hA5A5_0001, "R14 word 0 kept");

    // R13 idle: no rvalid
    repeat (3) @(negedge clk);
    chk({31'h0, bus_rvalid}, 32'h0, "R13 rvalid idle");
    chk(32'(q_exp.size()), 32'h0, "R13 all reads returned");

    done = 1'b1;
    report();
  end

endmodule